// File: doc/BRIEF.md
# Fractional Output Clock Divider

This block sits behind a frequency synthesizer and turns a fast source clock into a slower output clock. A 3-bit code chooses one of eight ratios, including the half-integer ratio 1.5, which is built by letting one flop act on rising source edges and a second flop act on falling source edges. The two flops combine into one output level. That level drives several identical complementary output pairs. A select input chooses the source: the synthesized clock when high, the reference clock when low, so the synthesizer can be bypassed.

An active-high master reset acts asynchronously. It clears every divider flop, drives each true output low and each complement output high, and keeps the loaded ratio from taking effect until release. A small sequencer sets the timing. In state SEQ_HOLD it waits in reset. The transition `release` occurs on the first rising source edge after reset drops. It loads the code and enters SEQ_RUN. In SEQ_RUN the transition `advance` steps a frame counter through the cycles of the current frame. The transition `wrap` restarts the counter at the end of a frame and loads the code present at that moment. Asserting reset from any state returns to SEQ_HOLD. A frame spans L source cycles: L is 3 for ratio 1.5 (two output periods) and N for every integer ratio N.

Top module: `fdiv_top`

## Requirements
- R1: Code 0..7 on `div_code` selects divide by 1, 1.5, 2, 3, 4, 6, 8 and 12. The output period is 2N half-periods of the selected source clock.
- R2: For each integer ratio N, the output is high for exactly N half-periods and low for N. It is high from the rising source edge that starts each period, which gives a 50% duty for even and odd N.
- R3: At ratio 1.5 the output period is three source half-periods, high for two and low for one. Successive periods start alternately on a rising and on a falling source edge.
- R4: While `rst` is high, every `out_p` bit is 0 and every `out_n` bit is 1. Asserting `rst` takes effect without waiting for a source edge.
- R5: After `rst` falls, the output rises on the first rising source edge and stays high for that first half-period.
- R6: Each `out_n` bit is always the inverse of the matching `out_p` bit.
- R7: All output pairs carry the same level at all times.
- R8: With `src_sel` = 1 the divider counts `vco_clk`. With `src_sel` = 0 it counts `ref_clk` instead, and `vco_clk` has no effect on the outputs.
- R9: A change of `div_code` inside a frame has no effect until that frame ends. The new ratio starts with a full period at the next frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Synthesized source clock |
| ref_clk | input | 1 | Reference clock used in bypass |
| src_sel | input | 1 | 1 selects `vco_clk`, 0 selects `ref_clk` |
| rst | input | 1 | Asynchronous master reset, active high |
| div_code | input | 3 | Ratio code, see R1 |
| out_p | output | NUM_PAIRS | True outputs, one per pair |
| out_n | output | NUM_PAIRS | Complement outputs, one per pair |

## Verification
The bench samples the output in every source half-period and compares it with a period and high-time pattern for every code. A design that handled the 1.5 ratio on one edge only would produce a three-cycle period and fail at the third half-slot. The first half-slot after reset release is checked on its own, so a design that needs a primer cycle shows up as a late first edge. The code is changed twice, mid-frame and during a high phase, and the remainder of each frame is checked to still follow the old ratio. A design that reloads at once would truncate the pulse, producing a runt. The bypass runs sample against reference-clock edges, so a divider that still counts the synthesized clock gives a wrong pattern. Reset is raised between source edges and checked 1 ns later, which catches a reset that waits for a clock.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    localparam int CODE_W = 3;
    localparam int CNT_W  = 4;
    localparam int HALF_W = CNT_W + 1;

    typedef enum logic [0:0] {
        SEQ_HOLD = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef enum logic [CODE_W-1:0] {
        DIV_1   = 3'd0,
        DIV_1P5 = 3'd1,
        DIV_2   = 3'd2,
        DIV_3   = 3'd3,
        DIV_4   = 3'd4,
        DIV_6   = 3'd5,
        DIV_8   = 3'd6,
        DIV_12  = 3'd7
    } ratio_e;

    // Source cycles in one frame; a frame always ends on a period boundary.
    function automatic logic [CNT_W-1:0] frame_cycles(input ratio_e c);
        logic [CNT_W-1:0] n;
        unique case (c)
            DIV_1:   n = CNT_W'(1);
            DIV_1P5: n = CNT_W'(3);
            DIV_2:   n = CNT_W'(2);
            DIV_3:   n = CNT_W'(3);
            DIV_4:   n = CNT_W'(4);
            DIV_6:   n = CNT_W'(6);
            DIV_8:   n = CNT_W'(8);
            DIV_12:  n = CNT_W'(12);
        endcase
        return n;
    endfunction

    // Half-periods of high level at the start of one output period.
    function automatic logic [HALF_W-1:0] high_halves(input ratio_e c);
        logic [HALF_W-1:0] n;
        unique case (c)
            DIV_1:   n = HALF_W'(1);
            DIV_1P5: n = HALF_W'(2);
            DIV_2:   n = HALF_W'(2);
            DIV_3:   n = HALF_W'(3);
            DIV_4:   n = HALF_W'(4);
            DIV_6:   n = HALF_W'(6);
            DIV_8:   n = HALF_W'(8);
            DIV_12:  n = HALF_W'(12);
        endcase
        return n;
    endfunction

    // Output level in half-slot h of a frame.
    function automatic logic half_level(input ratio_e c, input logic [HALF_W-1:0] h);
        logic [HALF_W-1:0] hm;
        if (c == DIV_1P5) begin
            hm = (h >= HALF_W'(3)) ? h - HALF_W'(3) : h;
            return hm < high_halves(c);
        end
        return h < high_halves(c);
    endfunction

endpackage

// File: rtl/fdiv_clk_sel.sv
module fdiv_clk_sel (
    input  logic vco_clk,
    input  logic ref_clk,
    input  logic src_sel,
    output logic div_clk
);
    always_comb begin
        div_clk = src_sel ? vco_clk : ref_clk;
    end
endmodule

// File: rtl/fdiv_seq.sv
module fdiv_seq
    import fdiv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CODE_W-1:0]    code_in,
    output logic                 run,
    output ratio_e               code_q,
    output logic [CNT_W-1:0]     cnt_q,
    output ratio_e               code_nxt,
    output logic [CNT_W-1:0]     cnt_nxt
);
    seq_state_e state_q, state_nxt;
    logic       last_cyc;

    assign last_cyc = (cnt_q == frame_cycles(code_q) - CNT_W'(1));

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= SEQ_HOLD;
            cnt_q   <= '0;
            code_q  <= DIV_1;
        end else begin
            state_q <= state_nxt;
            cnt_q   <= cnt_nxt;
            code_q  <= code_nxt;
        end
    end

    always_comb begin
        state_nxt = state_q;
        cnt_nxt   = cnt_q;
        code_nxt  = code_q;
        unique case (state_q)
            SEQ_HOLD: begin
                // release
                state_nxt = SEQ_RUN;
                cnt_nxt   = '0;
                code_nxt  = ratio_e'(code_in);
            end
            SEQ_RUN: begin
                if (last_cyc) begin
                    // wrap
                    cnt_nxt  = '0;
                    code_nxt = ratio_e'(code_in);
                end else begin
                    // advance
                    cnt_nxt  = cnt_q + CNT_W'(1);
                end
            end
        endcase
    end

    assign run = (state_q == SEQ_RUN);

    // R1
    cnt_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < frame_cycles(code_q));

    // R9
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_RUN && cnt_q != frame_cycles(code_q) - CNT_W'(1)) |=> $stable(code_q));

endmodule

// File: rtl/fdiv_edge_gen.sv
module fdiv_edge_gen
    import fdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  ratio_e           code_q,
    input  logic [CNT_W-1:0] cnt_q,
    input  ratio_e           code_nxt,
    input  logic [CNT_W-1:0] cnt_nxt,
    output logic             out_q
);
    logic rise_q;
    logic fall_q;

    // Rising edge sets the level of the even half-slot of the new cycle.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            rise_q <= 1'b0;
        end else begin
            rise_q <= half_level(code_nxt, {cnt_nxt, 1'b0}) ^ fall_q;
        end
    end

    // Falling edge sets the level of the odd half-slot of the current cycle.
    always_ff @(negedge clk or posedge rst) begin
        if (rst) begin
            fall_q <= 1'b0;
        end else if (!run) begin
            fall_q <= rise_q;
        end else begin
            fall_q <= half_level(code_q, {cnt_q, 1'b1}) ^ rise_q;
        end
    end

    assign out_q = rise_q ^ fall_q;

    // R5
    frame_start_high_chk: assert property (@(negedge clk) disable iff (rst)
        (run && cnt_q == '0) |-> out_q);

    // R2
    div2_second_low_chk: assert property (@(negedge clk) disable iff (rst)
        (run && code_q == DIV_2 && cnt_q == CNT_W'(1)) |-> !out_q);

    // R3
    frac_gap_chk: assert property (@(negedge clk) disable iff (rst)
        (run && code_q == DIV_1P5 && cnt_q == CNT_W'(1)) |-> !out_q);

endmodule

// File: rtl/fdiv_out_pairs.sv
module fdiv_out_pairs #(
    parameter int NUM_PAIRS = 2
) (
    input  logic                 level,
    output logic [NUM_PAIRS-1:0] pos,
    output logic [NUM_PAIRS-1:0] neg
);
    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
        assign pos[i] = level;
        assign neg[i] = ~level;
    end
endmodule

// File: rtl/fdiv_top.sv
module fdiv_top
    import fdiv_pkg::*;
#(
    parameter int NUM_PAIRS = 2
) (
    input  logic                 vco_clk,
    input  logic                 ref_clk,
    input  logic                 src_sel,
    input  logic                 rst,
    input  logic [2:0]           div_code,
    output logic [NUM_PAIRS-1:0] out_p,
    output logic [NUM_PAIRS-1:0] out_n
);
    logic             div_clk;
    logic             run;
    ratio_e           code_q;
    ratio_e           code_nxt;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             level;

    fdiv_clk_sel u_sel (
        .vco_clk (vco_clk),
        .ref_clk (ref_clk),
        .src_sel (src_sel),
        .div_clk (div_clk)
    );

    fdiv_seq u_seq (
        .clk      (div_clk),
        .rst      (rst),
        .code_in  (div_code),
        .run      (run),
        .code_q   (code_q),
        .cnt_q    (cnt_q),
        .code_nxt (code_nxt),
        .cnt_nxt  (cnt_nxt)
    );

    fdiv_edge_gen u_edge (
        .clk      (div_clk),
        .rst      (rst),
        .run      (run),
        .code_q   (code_q),
        .cnt_q    (cnt_q),
        .code_nxt (code_nxt),
        .cnt_nxt  (cnt_nxt),
        .out_q    (level)
    );

    fdiv_out_pairs #(.NUM_PAIRS(NUM_PAIRS)) u_pairs (
        .level (level),
        .pos   (out_p),
        .neg   (out_n)
    );

    // R4
    reset_level_chk: assert property (@(posedge div_clk)
        rst |-> (out_p == '0 && out_n == '1));

endmodule

// File: tb/test_fdiv_top.sv
module test_fdiv_top;

    logic       vco_clk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       src_sel = 1'b1;
    logic       rst     = 1'b0;
    logic [2:0] div_code = 3'd0;
    logic [1:0] out_p;
    logic [1:0] out_n;
    logic       watch_clk;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    // code, period in half-slots, high half-slots
    localparam int VEC [8][3] = '{
        '{0, 2, 1}, '{1, 3, 2}, '{2, 4, 2}, '{3, 6, 3},
        '{4, 8, 4}, '{5, 12, 6}, '{6, 16, 8}, '{7, 24, 12}
    };

    fdiv_top i_fdiv_top (
        .vco_clk  (vco_clk),
        .ref_clk  (ref_clk),
        .src_sel  (src_sel),
        .rst      (rst),
        .div_code (div_code),
        .out_p    (out_p),
        .out_n    (out_n)
    );

    always #5  vco_clk = ~vco_clk;
    always #15 ref_clk = ~ref_clk;
    assign watch_clk = src_sel ? vco_clk : ref_clk;

    task automatic check_bit(input string tag, input int slot, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s slot=%0d actual=%b expected=%b", tag, slot, act, exp);
        end
    endtask

    task automatic check_pairs(input int slot);
        checks++;
        if (out_p[1] !== out_p[0] || out_n !== ~out_p) begin
            failures++;
            $display("FAIL R6 R7 slot=%0d actual=p%b/n%b expected=equal pairs, n inverse of p",
                     slot, out_p, out_n);
        end
    endtask

    task automatic check_reset(input string ctx);
        checks++;
        if (out_p !== 2'b00 || out_n !== 2'b11) begin
            failures++;
            $display("FAIL R4 %s actual=p%b/n%b expected=p00/n11", ctx, out_p, out_n);
        end
    endtask

    task automatic start_run(input int code, input bit use_ref);
        rst      = 1'b1;
        src_sel  = !use_ref;
        div_code = code[2:0];
        repeat (3) @(posedge watch_clk);
        @(negedge watch_clk);
        #2 rst = 1'b0;
    endtask

    task automatic wait_slot(input int s);
        if (s % 2 == 0) @(posedge watch_clk);
        else            @(negedge watch_clk);
        #2;
    endtask

    task automatic run_pattern(input int code, input int per, input int hi,
                               input bit use_ref, input int nslots, input string tag);
        start_run(code, use_ref);
        for (int s = 0; s < nslots; s++) begin
            wait_slot(s);
            check_bit((s == 0) ? "R5" : tag, s, out_p[0], logic'((s % per) < hi));
            check_pairs(s);
        end
        rst = 1'b1;
        #1 check_reset("async assert");
    endtask

    initial begin
        #1 rst = 1'b1;
        // R4: reset state with both sources running
        for (int i = 0; i < 4; i++) begin
            @(posedge vco_clk); #2 check_reset("held vco");
        end
        src_sel = 1'b0;
        for (int i = 0; i < 2; i++) begin
            @(negedge ref_clk); #2 check_reset("held ref");
        end

        // R1 R2 R3: every ratio from the synthesized source
        for (int v = 0; v < 8; v++) begin
            run_pattern(VEC[v][0], VEC[v][1], VEC[v][2], 1'b0, 48,
                        (VEC[v][0] == 1) ? "R1 R3" : "R1 R2");
        end

        // R8: bypass counts the reference clock
        run_pattern(2, 4, 2, 1'b1, 24, "R8");
        run_pattern(0, 2, 1, 1'b1, 12, "R8");
        run_pattern(3, 6, 3, 1'b1, 24, "R8");

        // R9: code changes mid-frame only take effect at the frame boundary
        start_run(4, 1'b0);
        for (int s = 0; s < 24; s++) begin
            logic e;
            wait_slot(s);
            if (s < 8)       e = (s < 4);
            else if (s < 12) e = ((s - 8) < 2);
            else             e = (s % 2 == 0);
            check_bit("R9", s, out_p[0], e);
            check_pairs(s);
            if (s == 2) div_code = 3'd2;
            if (s == 9) div_code = 3'd0;
        end
        rst = 1'b1;
        #1 check_reset("after R9 run");

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule